// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Vector Consistency Gating

This block lets a scalar main core and a vector coprocessor share a single word-wide memory bus. Each requester presents a request that it holds until the block grants it in the same cycle. A granted request goes out on the downstream bus one cycle later as a single-cycle strobe. The block keeps an in-order record of which requester owns each outstanding transaction. It uses that record to steer every response back to the port that issued the request.

To keep memory consistent, the coprocessor supplies two status flags, one for a pending vector load and one for a pending vector store. When a vector store is pending, every main-core access is held back. When only a vector load is pending, main-core reads still go through but main-core writes wait. A held-back request is stalled, not dropped. Vector requests are never gated, and they win any tie with the main core.

Top module: `mem_share_arb`

## Requirements
- R1: With both pending flags low, a main-core read or write request with no vector request competing and room in the outstanding record is granted (`core_gnt_o` high) in the same cycle it is presented.
- R2: With the pending-load flag high and the pending-store flag low, main-core reads are granted and main-core writes (`core_we_i` = 1) are not granted.
- R3: With the pending-store flag high, no main-core request is granted, whatever the pending-load flag holds.
- R4: A main-core request that is held back is granted once the rule permits, and the bus then carries that request's own address, write enable and write data.
- R5: The pending flags never block a vector request. When both ports request in the same cycle, the vector port is granted and the main core is not.
- R6: `mem_req_o` is high for exactly one cycle per grant, in the cycle after the grant. In that cycle it carries the granted address, write enable, byte enables and write data. In cycles that follow no grant it is low.
- R7: The bus answers every request with exactly one `mem_rvalid_i` pulse, in request order, and this applies to writes as well as reads. One cycle after each pulse, the issuing port alone raises its rvalid, with the error flag and read data captured from the bus. The other port's rvalid stays low.
- R8: At most TAG_DEPTH transactions are outstanding. While that many are outstanding no grant is given, and granting resumes after a response frees a slot.
- R9: Reset (`rst` high, sampled on the clock edge) clears the outstanding record and drives all bus-request and response outputs low. After reset, a full TAG_DEPTH of grants is available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_pend_i | input | 1 | A vector load is in progress |
| st_pend_i | input | 1 | A vector store is in progress |
| core_req_i | input | 1 | Main-core request, held until granted |
| core_gnt_o | output | 1 | Main-core request accepted this cycle |
| core_addr_i | input | ADDR_W | Main-core word address |
| core_we_i | input | 1 | Main-core write (1) or read (0) |
| core_be_i | input | DATA_W/8 | Main-core byte enables |
| core_wdata_i | input | DATA_W | Main-core write data |
| core_rvalid_o | output | 1 | Response pulse for the main core |
| core_err_o | output | 1 | Error flag of the main-core response |
| core_rdata_o | output | DATA_W | Read data of the main-core response |
| vec_req_i | input | 1 | Vector request, held until granted |
| vec_gnt_o | output | 1 | Vector request accepted this cycle |
| vec_addr_i | input | ADDR_W | Vector word address |
| vec_we_i | input | 1 | Vector write (1) or read (0) |
| vec_be_i | input | DATA_W/8 | Vector byte enables |
| vec_wdata_i | input | DATA_W | Vector write data |
| vec_rvalid_o | output | 1 | Response pulse for the vector port |
| vec_err_o | output | 1 | Error flag of the vector response |
| vec_rdata_o | output | DATA_W | Read data of the vector response |
| mem_req_o | output | 1 | Bus request strobe, one cycle per transaction |
| mem_addr_o | output | ADDR_W | Bus word address |
| mem_we_o | output | 1 | Bus write enable |
| mem_be_o | output | DATA_W/8 | Bus byte enables |
| mem_wdata_o | output | DATA_W | Bus write data |
| mem_rvalid_i | input | 1 | Bus response pulse |
| mem_err_i | input | 1 | Bus error flag, valid with the response pulse |
| mem_rdata_i | input | DATA_W | Bus read data, valid with the response pulse |

## Verification
The bench builds the block with DATA_W = 32, ADDR_W = 32 and TAG_DEPTH = 3. A depth of three is not a power of two, so the record's read and write pointers must wrap explicitly, and the bench fills the record three times over. The depth is small enough that a bus model which withholds its responses can drive the record to full within a few cycles. This lets the bench reach the stall at the limit, the resumption after a freed slot, and the refill after a reset. Those runs are interleaved with requests under every combination of the pending flags and with simultaneous requests whose responses must be routed in order.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  // Owner of an outstanding bus transaction
  typedef enum logic {
    SRC_CORE = 1'b0,
    SRC_VEC  = 1'b1
  } src_e;
endpackage

// File: rtl/arb_gate.sv
module arb_gate (
  input  logic core_req,
  input  logic core_we,
  input  logic vec_req,
  input  logic ld_pend,
  input  logic st_pend,
  input  logic slots_full,
  output logic core_gnt,
  output logic vec_gnt
);
  logic core_allowed;

  // A store in flight blocks everything; a load in flight blocks writes only
  always_comb begin
    core_allowed = !st_pend && !(ld_pend && core_we);
    vec_gnt      = vec_req && !slots_full;
    core_gnt     = core_req && core_allowed && !vec_req && !slots_full;
  end
endmodule

// File: rtl/tag_fifo.sv
module tag_fifo
  import mem_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  src_e push_src,
  input  logic pop,
  output src_e head_src,
  output logic full,
  output logic empty
);
  src_e             slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign head_src = slots[rd_ptr];
  assign full     = (occ == CNT_W'(DEPTH));
  assign empty    = (occ == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) full |-> !push);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst) occ <= CNT_W'(DEPTH));
endmodule

// File: rtl/resp_route.sv
module resp_route
  import mem_arb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_data,
  input  src_e              owner,
  output logic              core_rvalid,
  output logic              core_err,
  output logic [DATA_W-1:0] core_rdata,
  output logic              vec_rvalid,
  output logic              vec_err,
  output logic [DATA_W-1:0] vec_rdata
);
  logic to_core, to_vec;

  assign to_core = rsp_valid && (owner == SRC_CORE);
  assign to_vec  = rsp_valid && (owner == SRC_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rvalid <= 1'b0;
      core_err    <= 1'b0;
      core_rdata  <= '0;
      vec_rvalid  <= 1'b0;
      vec_err     <= 1'b0;
      vec_rdata   <= '0;
    end else begin
      core_rvalid <= to_core;
      vec_rvalid  <= to_vec;
      if (to_core) begin
        core_err   <= rsp_err;
        core_rdata <= rsp_data;
      end
      if (to_vec) begin
        vec_err   <= rsp_err;
        vec_rdata <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb
  import mem_arb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int TAG_DEPTH = 4,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_pend_i,
  input  logic              st_pend_i,
  input  logic              core_req_i,
  output logic              core_gnt_o,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic              core_we_i,
  input  logic [BE_W-1:0]   core_be_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic              core_rvalid_o,
  output logic              core_err_o,
  output logic [DATA_W-1:0] core_rdata_o,
  input  logic              vec_req_i,
  output logic              vec_gnt_o,
  input  logic [ADDR_W-1:0] vec_addr_i,
  input  logic              vec_we_i,
  input  logic [BE_W-1:0]   vec_be_i,
  input  logic [DATA_W-1:0] vec_wdata_i,
  output logic              vec_rvalid_o,
  output logic              vec_err_o,
  output logic [DATA_W-1:0] vec_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic tags_full, tags_empty;
  logic any_gnt;
  src_e gnt_src, head_src;

  arb_gate u_gate (
    .core_req   (core_req_i),
    .core_we    (core_we_i),
    .vec_req    (vec_req_i),
    .ld_pend    (ld_pend_i),
    .st_pend    (st_pend_i),
    .slots_full (tags_full),
    .core_gnt   (core_gnt_o),
    .vec_gnt    (vec_gnt_o)
  );

  assign any_gnt = core_gnt_o || vec_gnt_o;
  assign gnt_src = vec_gnt_o ? SRC_VEC : SRC_CORE;

  // Bus launch register: one strobe per grant, fields from the winner
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_req_o <= any_gnt;
      if (any_gnt) begin
        mem_addr_o  <= vec_gnt_o ? vec_addr_i  : core_addr_i;
        mem_we_o    <= vec_gnt_o ? vec_we_i    : core_we_i;
        mem_be_o    <= vec_gnt_o ? vec_be_i    : core_be_i;
        mem_wdata_o <= vec_gnt_o ? vec_wdata_i : core_wdata_i;
      end
    end
  end

  tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .push     (any_gnt),
    .push_src (gnt_src),
    .pop      (mem_rvalid_i),
    .head_src (head_src),
    .full     (tags_full),
    .empty    (tags_empty)
  );

  resp_route #(.DATA_W(DATA_W)) u_route (
    .clk         (clk),
    .rst         (rst),
    .rsp_valid   (mem_rvalid_i),
    .rsp_err     (mem_err_i),
    .rsp_data    (mem_rdata_i),
    .owner       (head_src),
    .core_rvalid (core_rvalid_o),
    .core_err    (core_err_o),
    .core_rdata  (core_rdata_o),
    .vec_rvalid  (vec_rvalid_o),
    .vec_err     (vec_err_o),
    .vec_rdata   (vec_rdata_o)
  );

  // R3
  store_block_chk: assert property (@(posedge clk) disable iff (rst) st_pend_i |-> !core_gnt_o);
  // R2
  load_wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_pend_i && core_we_i) |-> !core_gnt_o);
  // R5
  vec_first_chk: assert property (@(posedge clk) disable iff (rst) vec_req_i |-> !core_gnt_o);
  // R6
  launch_chk: assert property (@(posedge clk) disable iff (rst) any_gnt |=> mem_req_o);
  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst) !any_gnt |=> !mem_req_o);
  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({core_rvalid_o, vec_rvalid_o}));
  // R7
  route_deliver_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid_i |=> (core_rvalid_o || vec_rvalid_o));
endmodule

// File: tb/mem_share_arb_test.sv
`timescale 1ns/1ps
module mem_share_arb_test;
  localparam int    DW     = 32;
  localparam int    AW     = 32;
  localparam int    DEPTH  = 3;
  localparam int    BW     = DW / 8;
  localparam real   CLK_NS = 5.0;

  typedef struct packed {
    logic          is_vec;
    logic          we;
    logic          ldp;
    logic          stp;
    logic          blocked;
    logic [31:0]   addr;
    logic [31:0]   wdata;
    logic [31:0]   exp_rd;
    logic          exp_err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h04, 32'hA1A10001, 32'h0,        1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h04, 32'h0,        32'hA1A10001, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h04, 32'h0,        32'hA1A10001, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h08, 32'hB2B20002, 32'h0,        1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h08, 32'h0,        32'hB2B20002, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0C, 32'hC3C30003, 32'h0,        1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0C, 32'h0,        32'hC3C30003, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h80, 32'h0,        32'h0,        1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h44, 32'h5,        32'h0,        1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_pend_i = 1'b0, st_pend_i = 1'b0;
  logic core_req_i = 1'b0, core_we_i = 1'b0;
  logic [AW-1:0] core_addr_i = '0;
  logic [BW-1:0] core_be_i = '0;
  logic [DW-1:0] core_wdata_i = '0;
  logic vec_req_i = 1'b0, vec_we_i = 1'b0;
  logic [AW-1:0] vec_addr_i = '0;
  logic [BW-1:0] vec_be_i = '0;
  logic [DW-1:0] vec_wdata_i = '0;
  logic mem_rvalid_i = 1'b0, mem_err_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic core_gnt_o, core_rvalid_o, core_err_o, vec_gnt_o, vec_rvalid_o, vec_err_o;
  logic [DW-1:0] core_rdata_o, vec_rdata_o, mem_wdata_o;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [BW-1:0] mem_be_o;

  int  n_chk = 0, n_fail = 0;
  int  crv = 0, vrv = 0;
  bit  hold = 1'b0;
  bit  done = 1'b0;
  logic [31:0] mem_w [16];
  logic [32:0] rq [$];

  always #(CLK_NS / 2.0) clk = ~clk;

  mem_share_arb #(.DATA_W(DW), .ADDR_W(AW), .TAG_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .ld_pend_i(ld_pend_i), .st_pend_i(st_pend_i),
    .core_req_i(core_req_i), .core_gnt_o(core_gnt_o), .core_addr_i(core_addr_i),
    .core_we_i(core_we_i), .core_be_i(core_be_i), .core_wdata_i(core_wdata_i),
    .core_rvalid_o(core_rvalid_o), .core_err_o(core_err_o), .core_rdata_o(core_rdata_o),
    .vec_req_i(vec_req_i), .vec_gnt_o(vec_gnt_o), .vec_addr_i(vec_addr_i),
    .vec_we_i(vec_we_i), .vec_be_i(vec_be_i), .vec_wdata_i(vec_wdata_i),
    .vec_rvalid_o(vec_rvalid_o), .vec_err_o(vec_err_o), .vec_rdata_o(vec_rdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic drive_req(input bit is_vec, input bit on, input bit we,
                           input logic [31:0] addr, input logic [31:0] wd);
    if (is_vec) begin
      vec_req_i = on; vec_we_i = we; vec_addr_i = addr; vec_wdata_i = wd; vec_be_i = '1;
    end else begin
      core_req_i = on; core_we_i = we; core_addr_i = addr; core_wdata_i = wd; core_be_i = '1;
    end
  endtask

  // Bus model: in-order responses, one per request, withheld while hold is set
  initial begin
    for (int i = 0; i < 16; i++) mem_w[i] = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        rq.delete();
        mem_rvalid_i = 1'b0;
      end else begin
        logic [32:0] e;
        mem_rvalid_i = 1'b0;
        if (!hold && rq.size() > 0) begin
          e = rq.pop_front();
          mem_err_i    = e[32];
          mem_rdata_i  = e[31:0];
          mem_rvalid_i = 1'b1;
        end
        if (mem_req_o) begin
          logic bad;
          bad = (mem_addr_o >= 32'h40);
          if (mem_we_o) begin
            if (!bad)
              for (int b = 0; b < BW; b++)
                if (mem_be_o[b]) mem_w[mem_addr_o[5:2]][b*8 +: 8] = mem_wdata_o[b*8 +: 8];
            rq.push_back({bad, 32'h0});
          end else begin
            rq.push_back({bad, bad ? 32'h0 : mem_w[mem_addr_o[5:2]]});
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (core_rvalid_o) crv++;
      if (vec_rvalid_o)  vrv++;
    end
  end

  initial begin
    #(CLK_NS * 20000.0);
    chk(1'b0, "all", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  task automatic run_vector(input vec_t v);
    string tg;
    bit got;
    tg = v.blocked ? (v.stp ? "R3" : "R2") : (v.is_vec ? "R5" : (v.ldp ? "R2" : "R1"));
    @(negedge clk);
    ld_pend_i = v.ldp; st_pend_i = v.stp;
    drive_req(v.is_vec, 1'b1, v.we, v.addr, v.wdata);
    #1;
    if (v.blocked) begin
      for (int k = 0; k < 3; k++) begin
        chk(core_gnt_o == 1'b0, tg, "held request granted", 32'(core_gnt_o), 32'h0);
        @(negedge clk); #1;
        chk(mem_req_o == 1'b0, tg, "bus strobe while held", 32'(mem_req_o), 32'h0);
      end
      ld_pend_i = 1'b0; st_pend_i = 1'b0;
      #1;
      tg = "R4";
    end
    chk((v.is_vec ? vec_gnt_o : core_gnt_o) == 1'b1, tg, "grant", 32'h0, 32'h1);
    @(negedge clk);
    chk(mem_req_o == 1'b1, "R6", "bus strobe after grant", 32'(mem_req_o), 32'h1);
    chk(mem_addr_o == v.addr, v.blocked ? "R4" : "R6", "bus address", mem_addr_o, v.addr);
    chk(mem_we_o == v.we, "R6", "bus write enable", 32'(mem_we_o), 32'(v.we));
    if (v.we) chk(mem_wdata_o == v.wdata, "R6", "bus write data", mem_wdata_o, v.wdata);
    drive_req(v.is_vec, 1'b0, 1'b0, 32'h0, 32'h0);
    got = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0) chk(mem_req_o == 1'b0, "R6", "strobe longer than one cycle", 32'(mem_req_o), 32'h0);
      if (v.is_vec ? vec_rvalid_o : core_rvalid_o) begin
        got = 1'b1;
        chk((v.is_vec ? vec_rdata_o : core_rdata_o) == v.exp_rd, "R7", "response data",
            v.is_vec ? vec_rdata_o : core_rdata_o, v.exp_rd);
        chk((v.is_vec ? vec_err_o : core_err_o) == v.exp_err, "R7", "response error",
            32'(v.is_vec ? vec_err_o : core_err_o), 32'(v.exp_err));
      end
      if (v.is_vec ? core_rvalid_o : vec_rvalid_o)
        chk(1'b0, "R7", "response on wrong port", 32'h1, 32'h0);
    end
    chk(got, "R7", "response delivered", 32'(got), 32'h1);
    ld_pend_i = 1'b0; st_pend_i = 1'b0;
  endtask

  initial begin
    // Reset state (R9)
    repeat (3) @(negedge clk);
    chk(mem_req_o == 1'b0 && core_rvalid_o == 1'b0 && vec_rvalid_o == 1'b0, "R9",
        "outputs in reset", {29'h0, mem_req_o, core_rvalid_o, vec_rvalid_o}, 32'h0);
    chk(core_rdata_o == '0 && vec_rdata_o == '0, "R9", "read data in reset",
        core_rdata_o | vec_rdata_o, 32'h0);
    rst = 1'b0;

    // Vector table walk
    for (int i = 0; i < NV; i++) run_vector(TBL[i]);

    // Tie: vector wins, stalled core follows, responses in order (R5, R4, R7)
    @(negedge clk);
    drive_req(1'b0, 1'b1, 1'b0, 32'h04, 32'h0);
    drive_req(1'b1, 1'b1, 1'b0, 32'h0C, 32'h0);
    #1;
    chk(vec_gnt_o == 1'b1 && core_gnt_o == 1'b0, "R5", "tie grant {vec,core}",
        {30'h0, vec_gnt_o, core_gnt_o}, 32'h2);
    @(negedge clk);
    drive_req(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    #1;
    chk(core_gnt_o == 1'b1, "R4", "stalled core granted after tie", 32'(core_gnt_o), 32'h1);
    begin
      bit seen_v, seen_c;
      seen_v = 1'b0; seen_c = 1'b0;
      @(negedge clk);
      drive_req(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (vec_rvalid_o) begin
          seen_v = 1'b1;
          chk(vec_rdata_o == 32'hC3C30003, "R7", "vector tie data", vec_rdata_o, 32'hC3C30003);
        end
        if (core_rvalid_o) begin
          seen_c = 1'b1;
          chk(seen_v, "R7", "core response before vector", 32'(seen_v), 32'h1);
          chk(core_rdata_o == 32'hA1A10001, "R7", "core tie data", core_rdata_o, 32'hA1A10001);
        end
      end
      chk(seen_v && seen_c, "R7", "both tie responses", {30'h0, seen_v, seen_c}, 32'h3);
    end

    // Outstanding limit (R8)
    vrv = 0;
    hold = 1'b1;
    @(negedge clk);
    drive_req(1'b1, 1'b1, 1'b0, 32'h04, 32'h0);
    #1;
    for (int k = 0; k < DEPTH; k++) begin
      chk(vec_gnt_o == 1'b1, "R8", "grant below limit", 32'(vec_gnt_o), 32'h1);
      @(negedge clk); #1;
    end
    for (int k = 0; k < 3; k++) begin
      chk(vec_gnt_o == 1'b0, "R8", "grant at limit", 32'(vec_gnt_o), 32'h0);
      @(negedge clk); #1;
    end
    hold = 1'b0;
    begin
      bit resumed;
      resumed = 1'b0;
      for (int k = 0; k < 4 && !resumed; k++) begin
        @(negedge clk); #1;
        if (vec_gnt_o) resumed = 1'b1;
      end
      chk(resumed, "R8", "grant resumes after response", 32'(resumed), 32'h1);
    end
    @(negedge clk);
    drive_req(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    repeat (12) @(negedge clk);
    chk(vrv == DEPTH + 1, "R8", "responses after limit", vrv, DEPTH + 1);

    // Reset clears the outstanding record (R9)
    hold = 1'b1;
    @(negedge clk);
    drive_req(1'b1, 1'b1, 1'b0, 32'h08, 32'h0);
    repeat (2) @(negedge clk);
    drive_req(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(mem_req_o == 1'b0 && vec_rvalid_o == 1'b0 && core_rvalid_o == 1'b0, "R9",
        "outputs after reset", {29'h0, mem_req_o, core_rvalid_o, vec_rvalid_o}, 32'h0);
    drive_req(1'b1, 1'b1, 1'b0, 32'h08, 32'h0);
    #1;
    for (int k = 0; k < DEPTH; k++) begin
      chk(vec_gnt_o == 1'b1, "R9", "record empty after reset", 32'(vec_gnt_o), 32'h1);
      @(negedge clk); #1;
    end
    chk(vec_gnt_o == 1'b0, "R9", "limit after reset", 32'(vec_gnt_o), 32'h0);
    drive_req(1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
    vrv = 0;
    hold = 1'b0;
    repeat (12) @(negedge clk);
    chk(vrv == DEPTH, "R9", "responses after reset", vrv, DEPTH);

    finish_run();
  end
endmodule